// File: doc/BRIEF.md
# Gated Pulse-Count Wiper Setter

This block drives a digital potentiometer that has an increment, up/down and chip-select control interface. The wiper is moved to a tap proportional to the rate of an external pulse stream, such as the output of a voltage-to-frequency converter. The tap is never computed. A calibrate request opens a timing window of fixed length. Every rising edge of the pulse stream seen while the window is open becomes one increment strobe, and the direction line stays at up. The number of pulses that fit in the window is therefore the tap. The window length is chosen as the highest tap divided by the full-scale pulse rate, so full scale lands on the top tap.

The calibrate input may come from a mechanical switch or from a processor. It is synchronized and debounced: a rising level is accepted only after it has held for a set number of clocks, and each accepted rise opens exactly one window. The pulse input is asynchronous. It passes through a two-flop synchronizer and an edge detector. A per-window tap counter assumes the wiper starts from tap 0 and stops issuing strobes once the top tap is reached.

The sequencer has four states:
- IDLE: chip select is inactive.
- ARM: one setup cycle with chip select active.
- OPEN: the gate, lasting `GATE_CYCLES` clocks.
- CLOSE: one hold cycle, so the last strobe stays inside the selected period.

Its transitions are IDLE to ARM on an accepted calibrate, ARM to OPEN always, OPEN to CLOSE when the gate count expires, and CLOSE to IDLE always.

Top module: `wiper_gate_top`

## Requirements
- R1: After reset, `pot_cs_n` is 1, `pot_inc` is 0, `busy` is 0 and `pot_up` is 1.
- R2: A rise on `cal_in` opens a window only after `cal_in` has stayed high for `DEB_CYCLES` consecutive synchronized clocks. A high pulse shorter than that opens no window, and each accepted rise opens exactly one window.
- R3: A window holds `busy` at 1 and `pot_cs_n` at 0 for exactly `GATE_CYCLES`+2 consecutive clocks. At all times `busy` equals the inverse of `pot_cs_n`.
- R4: Each rising edge of `pulse_in` during the gate produces a strobe: `pot_inc` is high for exactly one clock, three clock edges after the input rise.
- R5: Within one window, no more than `TAPS`-1 strobes are issued; extra pulses are dropped.
- R6: No strobe is issued while no window is open. `pot_inc` is 0 whenever `pot_cs_n` is 1.
- R7: `pot_up` is 1 at all times; 1 means the wiper moves up.
- R8: A calibrate request accepted while `busy` is 1 is ignored. The window keeps its length and no second window follows.
- R9: The tap counter restarts from 0 at the start of every window, so each window's strobe count depends only on its own pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse stream from the frequency source |
| cal_in | input | 1 | Calibrate request, from a switch or a processor |
| pot_inc | output | 1 | Increment strobe, one clock high per step |
| pot_up | output | 1 | Direction, 1 = up |
| pot_cs_n | output | 1 | Potentiometer chip select, active low |
| busy | output | 1 | High while a window is in progress |

## Verification
Faults inside the block show up at the ports within one window.
- A gate counter that stops at the wrong value shows as a `busy` period that is not `GATE_CYCLES`+2 clocks long, visible when `busy` falls.
- A tap counter that is not cleared, or that saturates at the wrong value, shows as a wrong number of `pot_inc` strobes for a known pulse count.
- A broken synchronizer or edge detector shows within three clocks of a pulse, as a missing, doubled or late strobe.
- A debouncer or sequencer that accepts a short glitch, or re-arms during a window, produces an extra `busy` period. The bench's queue of expected windows has no entry for it.

// File: rtl/wiper_gate_pkg.sv
package wiper_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_OPEN  = 2'd2,
        ST_CLOSE = 2'd3
    } gate_state_t;
endpackage

// File: rtl/wg_edge_sync.sv
module wg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

    // R4: a detected edge lasts a single cycle
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/wg_debounce.sv
module wg_debounce #(
    parameter int DEB_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic trig
);
    localparam int DW = $clog2(DEB_CYCLES + 1);
    localparam logic [DW-1:0] LAST = DW'(DEB_CYCLES - 1);

    logic          s_a, s_b;
    logic          stable;
    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_a <= 1'b0;
            s_b <= 1'b0;
        end else begin
            s_a <= raw_in;
            s_b <= s_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable <= 1'b0;
            cnt    <= '0;
            trig   <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (s_b == stable) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                stable <= s_b;
                cnt    <= '0;
                trig   <= s_b;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: one trigger per accepted rise
    a_r2_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
    // R2: a trigger only follows a change to the accepted level
    a_r2_trig_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> stable && !$past(stable));
endmodule

// File: rtl/wg_gate_fsm.sv
module wg_gate_fsm
    import wiper_gate_pkg::*;
#(
    parameter int GATE_CYCLES = 3875000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic win_clear,
    output logic gate_open,
    output logic cs_n,
    output logic busy
);
    localparam int GW = $clog2(GATE_CYCLES + 1);
    localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

    gate_state_t   state, nstate;
    logic [GW-1:0] cnt;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_ARM;
            ST_ARM:   nstate = ST_OPEN;
            ST_OPEN:  if (cnt == LAST) nstate = ST_CLOSE;
            ST_CLOSE: nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            if (state == ST_OPEN) cnt <= cnt + 1'b1;
            else                  cnt <= '0;
        end
    end

    always_comb begin
        win_clear = 1'b0;
        gate_open = 1'b0;
        cs_n      = 1'b1;
        unique case (state)
            ST_IDLE:  ;
            ST_ARM:   begin win_clear = 1'b1; cs_n = 1'b0; end
            ST_OPEN:  begin gate_open = 1'b1; cs_n = 1'b0; end
            ST_CLOSE: cs_n = 1'b0;
            default:  ;
        endcase
        busy = ~cs_n;
    end

    // R3: the gate counter never passes its terminal value
    a_r3_gate_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |-> (cnt <= LAST));
    // R8: no re-arm while a window is in progress
    a_r8_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_ARM));
    // R3: the window is entered only from setup
    a_r3_open_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(state) == ST_ARM);
endmodule

// File: rtl/wg_strobe.sv
module wg_strobe #(
    parameter int TAPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_clear,
    input  logic gate_open,
    input  logic edge_in,
    output logic inc
);
    localparam int TW = $clog2(TAPS);
    localparam logic [TW-1:0] TOP = TW'(TAPS - 1);

    logic [TW-1:0] tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap <= '0;
            inc <= 1'b0;
        end else begin
            inc <= 1'b0;
            if (win_clear) begin
                tap <= '0;
            end else if (gate_open && edge_in && tap != TOP) begin
                tap <= tap + 1'b1;
                inc <= 1'b1;
            end
        end
    end

    // R5: the tap counter saturates at the top tap
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        tap <= TOP);
    // R6: a strobe only follows a cycle with the gate open
    a_r6_inc_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> $past(gate_open));
    // R9: the window starts from tap zero
    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        win_clear |=> tap == '0);
endmodule

// File: rtl/wiper_gate_top.sv
module wiper_gate_top #(
    parameter int GATE_CYCLES = 3875000,
    parameter int TAPS        = 32,
    parameter int DEB_CYCLES  = 12500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic cal_in,
    output logic pot_inc,
    output logic pot_up,
    output logic pot_cs_n,
    output logic busy
);
    logic cal_trig;
    logic pulse_rise;
    logic win_clear;
    logic gate_open;

    wg_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
        .clk(clk), .rst_n(rst_n), .raw_in(cal_in), .trig(cal_trig)
    );

    wg_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pulse_in), .rise(pulse_rise)
    );

    wg_gate_fsm #(.GATE_CYCLES(GATE_CYCLES)) i_fsm (
        .clk(clk), .rst_n(rst_n), .start(cal_trig),
        .win_clear(win_clear), .gate_open(gate_open),
        .cs_n(pot_cs_n), .busy(busy)
    );

    wg_strobe #(.TAPS(TAPS)) i_strobe (
        .clk(clk), .rst_n(rst_n), .win_clear(win_clear),
        .gate_open(gate_open), .edge_in(pulse_rise), .inc(pot_inc)
    );

    assign pot_up = 1'b1;

    // R6: no strobe while the part is deselected
    a_r6_inc_selected: assert property (@(posedge clk) disable iff (!rst_n)
        pot_inc |-> !pot_cs_n);
    // R4: strobes are one cycle wide
    a_r4_inc_single: assert property (@(posedge clk) disable iff (!rst_n)
        pot_inc |=> !pot_inc);
    // R3: busy mirrors chip select
    a_r3_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
        busy != pot_cs_n);
endmodule

// File: tb/test_wiper_gate_top.sv
module test_wiper_gate_top;
    localparam int GATE = 400;
    localparam int TAPS = 32;
    localparam int DEB  = 8;
    localparam int WIN_LEN = GATE + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0;
    logic cal_in = 1'b0;
    logic pot_inc, pot_up, pot_cs_n, busy;

    int checks = 0;
    int fails = 0;
    int windows_seen = 0;
    int stray_inc = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wiper_gate_top #(.GATE_CYCLES(GATE), .TAPS(TAPS), .DEB_CYCLES(DEB)) i_wiper_gate_top (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .cal_in(cal_in),
        .pot_inc(pot_inc), .pot_up(pot_up), .pot_cs_n(pot_cs_n), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures each window and compares against the queue
    bit in_win = 1'b0;
    int len = 0, incs = 0, upbad = 0, csbad = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy == pot_cs_n) csbad++;
            if (busy) begin
                if (!in_win) begin
                    in_win = 1'b1; len = 0; incs = 0; upbad = 0; csbad = 0;
                end
                len++;
                if (pot_inc) incs++;
                if (!pot_up) upbad++;
            end else begin
                if (pot_inc) stray_inc++;
                if (in_win) begin
                    in_win = 1'b0;
                    windows_seen++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2/R8 unexpected window", windows_seen, 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(len == WIN_LEN, "R3 window length", len, WIN_LEN);
                        check(incs == e, "R4/R5/R9 strobe count", incs, e);
                        check(upbad == 0 && csbad == 0, "R7/R3 up held and busy/cs", upbad + csbad, 0);
                    end
                end
            end
        end
    end

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pulse_in = 1'b1;
            repeat (4) @(negedge clk);
            pulse_in = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic press();
        @(negedge clk) cal_in = 1'b1;
        repeat (20) @(negedge clk);
        cal_in = 1'b0;
    endtask

    // driver: one window with n pulses, expected count pushed to the queue
    task automatic run_window(input int n, input bit recal);
        int e;
        e = (n > TAPS - 1) ? TAPS - 1 : n;
        exp_q.push_back(e);
        press();
        while (!busy) @(negedge clk);
        repeat (20) @(negedge clk);
        pulses(n);
        if (recal) press();
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pot_cs_n == 1'b1, "R1 cs_n", pot_cs_n, 1);
        check(pot_inc == 1'b0, "R1 inc", pot_inc, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(pot_up == 1'b1, "R1 up", pot_up, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6: pulses with no window give nothing
        pulses(5);
        repeat (10) @(negedge clk);
        check(stray_inc == 0 && windows_seen == 0, "R6 idle pulses", stray_inc, 0);

        // R2: short glitch opens no window
        @(negedge clk) cal_in = 1'b1;
        repeat (3) @(negedge clk);
        cal_in = 1'b0;
        repeat (40) @(negedge clk);
        check(windows_seen == 0 && busy == 1'b0, "R2 glitch rejected", windows_seen, 0);

        // R4 latency in a one-pulse window
        exp_q.push_back(1);
        press();
        while (!busy) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(pot_inc == 1'b0, "R4 no early strobe", pot_inc, 0);
        @(posedge clk);
        @(negedge clk);
        check(pot_inc == 1'b1, "R4 strobe at third edge", pot_inc, 1);
        @(negedge clk);
        check(pot_inc == 1'b0, "R4 strobe one cycle", pot_inc, 0);
        repeat (3) @(negedge clk);
        pulse_in = 1'b0;
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);

        run_window(0, 1'b0);   // R4 empty window
        run_window(5, 1'b0);   // R4
        run_window(31, 1'b0);  // R5 exactly top tap
        run_window(35, 1'b0);  // R5 saturation
        run_window(3, 1'b0);   // R9 restart from zero after saturation
        run_window(4, 1'b1);   // R8 calibrate during window ignored
        repeat (100) @(negedge clk);

        check(exp_q.size() == 0, "R2/R8 all windows seen", exp_q.size(), 0);
        check(windows_seen == 7, "R8 window total", windows_seen, 7);
        check(stray_inc == 0, "R6 no stray strobes", stray_inc, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule